// File: doc/BRIEF.md
# Per-Line Event Interrupt Detector

This block watches a bank of input lines and, for each one, looks for a programmable event: a rising edge, a falling edge, any edge, a held low level or a held high level. Each line carries its own 3-bit event code and its own pair of glitch-filter enables as configuration inputs. Detected events are latched in a status word that clears itself when software reads it, and the latched events of the enabled lines are merged into one interrupt output for the whole bank.

Software reaches the block through a single-cycle word bus with four word addresses: one that turns line interrupts on, one that turns them off, one that reads back the enabled set and one that reads and clears the status. Each line passes through a synchronizer. It can then pass through a glitch filter that is paced by a slow-clock enable pulse, issued once per half slow-clock period, before the edge or level decode.

Top module: `line_event_irq`

## Requirements
- R1: After reset the enabled set and the status word are all zero and `irq_o` is low.
- R2: Per line, event code 0 detects a falling edge, 1 a rising edge, 2 either edge, 3 a low level and 4 a high level; codes 5, 6 and 7 never set a status bit. Line n uses `evt_sel_i[3n+2:3n]`.
- R3: A write to address 0x20 sets every enable bit whose write-data bit is 1. A write to 0x24 clears every enable bit whose write-data bit is 1. A read of 0x28 returns the enabled set, with bit n standing for line n.
- R4: A read of address 0x2C returns the status word (bit n for line n) in the same cycle and clears it at the end of that cycle.
- R5: An event detected in the same cycle as a status read is still recorded: its bit is 1 after the clear. A line change becomes visible in the status word at the third rising clock edge after it is applied.
- R6: A level event sets its status bit on every cycle that the level holds, so the bit reads 1 again straight after a read while the level persists.
- R7: Status bits latch whether or not the line is enabled, and a bit stays set until the status word is read.
- R8: `irq_o` is high exactly when some line has both its status bit and its enable bit set. Once all enable bits are cleared, `irq_o` is low in the following cycle.
- R9: When both `filt_en_i[n]` and `filt_slow_i[n]` are 1, line n changes its filtered value only after the same value has been sampled at two consecutive `slow_tick_i` pulses. A pulse that spans fewer than two ticks is therefore rejected. If either enable is 0, the line is not filtered.
- R10: No event is reported during the first SYNC_STAGES+2 cycles after reset. An input that is already at a steady level when reset ends produces no edge event.
- R11: Reads of any address other than 0x28 and 0x2C return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_i | input | NUM_LINES | Monitored asynchronous lines |
| evt_sel_i | input | 3*NUM_LINES | Per-line event code, 3 bits per line |
| filt_en_i | input | NUM_LINES | Per-line glitch filter enable |
| filt_slow_i | input | NUM_LINES | Per-line slow-clock pacing enable for the filter |
| slow_tick_i | input | 1 | One-cycle pulse once per half slow-clock period |
| bus_sel_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | Bus write (1) or read (0) |
| bus_addr_i | input | ADDR_W | Byte address of the word |
| bus_wdata_i | input | NUM_LINES | Write data |
| bus_rdata_o | output | NUM_LINES | Read data, valid in the access cycle |
| irq_o | output | 1 | Bank interrupt |

## Verification
On every cycle the assertions check that enable writes set and clear exactly the written bits, and that a status read with no event in flight empties the status word. They also check that status bits never drop without a read and that every detected event lands in the status word. Finally they check that nothing is detected during the warm-up after reset and that clearing all enables drops the interrupt. Only the bench scenarios can show the decode of each event code against real line waveforms and the reassertion of level events after a read. The same holds for the exact cycle at which a change arriving during a read is kept, and for the filter rejecting short pulses while passing long ones.

// File: rtl/lei_pkg.sv
package lei_pkg;
  typedef enum logic [2:0] {
    EVT_FALL = 3'd0,
    EVT_RISE = 3'd1,
    EVT_BOTH = 3'd2,
    EVT_LOW  = 3'd3,
    EVT_HIGH = 3'd4
  } evt_code_e;

  localparam logic [7:0] OFS_IRQ_ON   = 8'h20;
  localparam logic [7:0] OFS_IRQ_OFF  = 8'h24;
  localparam logic [7:0] OFS_IRQ_SET  = 8'h28;
  localparam logic [7:0] OFS_IRQ_STAT = 8'h2C;
endpackage

// File: rtl/lei_sync.sv
module lei_sync #(
  parameter int N      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/lei_filter.sv
module lei_filter (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic tick_i,
  input  logic en_i,
  input  logic slow_en_i,
  input  logic d_i,
  output logic q_o
);
  logic smp_q, hold_q;
  logic bypass;

  assign bypass = !(en_i && slow_en_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smp_q  <= 1'b0;
      hold_q <= 1'b0;
    end else if (load_i || bypass) begin
      smp_q  <= d_i;
      hold_q <= d_i;
    end else if (tick_i) begin
      smp_q <= d_i;
      // value must be seen at two consecutive ticks
      if (d_i == smp_q) hold_q <= d_i;
    end
  end

  assign q_o = bypass ? d_i : hold_q;
endmodule

// File: rtl/lei_detect.sv
module lei_detect
  import lei_pkg::*;
#(
  parameter int N = 32
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           warm_i,
  input  logic [N-1:0]   cur_i,
  input  logic [3*N-1:0] sel_i,
  output logic [N-1:0]   evt_o
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= cur_i;
  end

  for (genvar l = 0; l < N; l++) begin : g_line
    logic rise, fall, hit;
    assign rise = cur_i[l] && !prev_q[l];
    assign fall = !cur_i[l] && prev_q[l];
    always_comb begin
      unique case (sel_i[3*l +: 3])
        EVT_FALL: hit = fall;
        EVT_RISE: hit = rise;
        EVT_BOTH: hit = rise || fall;
        EVT_LOW:  hit = !cur_i[l];
        EVT_HIGH: hit = cur_i[l];
        default:  hit = 1'b0;
      endcase
    end
    assign evt_o[l] = warm_i && hit;
  end
endmodule

// File: rtl/lei_regs.sv
module lei_regs
  import lei_pkg::*;
#(
  parameter int N      = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [N-1:0]      bus_wdata_i,
  input  logic [N-1:0]      evt_i,
  output logic [N-1:0]      bus_rdata_o,
  output logic [N-1:0]      mask_o,
  output logic [N-1:0]      stat_o,
  output logic              irq_o
);
  logic [N-1:0] mask_q, stat_q;
  logic wr_on, wr_off, rd_stat;

  assign wr_on   = bus_sel_i && bus_we_i && (bus_addr_i == ADDR_W'(OFS_IRQ_ON));
  assign wr_off  = bus_sel_i && bus_we_i && (bus_addr_i == ADDR_W'(OFS_IRQ_OFF));
  assign rd_stat = bus_sel_i && !bus_we_i && (bus_addr_i == ADDR_W'(OFS_IRQ_STAT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      stat_q <= '0;
    end else begin
      if (wr_on)       mask_q <= mask_q | bus_wdata_i;
      else if (wr_off) mask_q <= mask_q & ~bus_wdata_i;
      // events of the read cycle survive the clear
      stat_q <= (rd_stat ? '0 : stat_q) | evt_i;
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    if (bus_addr_i == ADDR_W'(OFS_IRQ_SET))       bus_rdata_o = mask_q;
    else if (bus_addr_i == ADDR_W'(OFS_IRQ_STAT)) bus_rdata_o = stat_q;
  end

  assign irq_o  = |(stat_q & mask_q);
  assign mask_o = mask_q;
  assign stat_o = stat_q;
endmodule

// File: rtl/line_event_irq.sv
module line_event_irq #(
  parameter int NUM_LINES   = 32,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NUM_LINES-1:0]   line_i,
  input  logic [3*NUM_LINES-1:0] evt_sel_i,
  input  logic [NUM_LINES-1:0]   filt_en_i,
  input  logic [NUM_LINES-1:0]   filt_slow_i,
  input  logic                   slow_tick_i,
  input  logic                   bus_sel_i,
  input  logic                   bus_we_i,
  input  logic [ADDR_W-1:0]      bus_addr_i,
  input  logic [NUM_LINES-1:0]   bus_wdata_i,
  output logic [NUM_LINES-1:0]   bus_rdata_o,
  output logic                   irq_o
);
  localparam int WARM   = SYNC_STAGES + 2;
  localparam int WARM_W = $clog2(WARM + 1);

  logic [NUM_LINES-1:0] sync_w, filt_w, evt_w, mask_w, stat_w;
  logic [WARM_W-1:0]    warm_cnt_q;
  logic                 warm_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      warm_cnt_q <= '0;
    else if (!warm_w) warm_cnt_q <= warm_cnt_q + 1'b1;
  end
  assign warm_w = (warm_cnt_q == WARM_W'(WARM));

  lei_sync #(.N(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (line_i),
    .q_o   (sync_w)
  );

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_filt
    lei_filter u_filt (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .load_i   (!warm_w),
      .tick_i   (slow_tick_i),
      .en_i     (filt_en_i[l]),
      .slow_en_i(filt_slow_i[l]),
      .d_i      (sync_w[l]),
      .q_o      (filt_w[l])
    );
  end

  lei_detect #(.N(NUM_LINES)) u_det (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .warm_i(warm_w),
    .cur_i (filt_w),
    .sel_i (evt_sel_i),
    .evt_o (evt_w)
  );

  lei_regs #(.N(NUM_LINES), .ADDR_W(ADDR_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bus_sel_i  (bus_sel_i),
    .bus_we_i   (bus_we_i),
    .bus_addr_i (bus_addr_i),
    .bus_wdata_i(bus_wdata_i),
    .evt_i      (evt_w),
    .bus_rdata_o(bus_rdata_o),
    .mask_o     (mask_w),
    .stat_o     (stat_w),
    .irq_o      (irq_o)
  );
endmodule

// File: rtl/lei_chk.sv
module lei_chk #(
  parameter int N      = 32,
  parameter int ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_sel_i,
  input logic              bus_we_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [N-1:0]      bus_wdata_i,
  input logic              irq_o,
  input logic [N-1:0]      mask_i,
  input logic [N-1:0]      stat_i,
  input logic [N-1:0]      evt_i,
  input logic              warm_i
);
  logic wr_on, wr_off, rd_stat;
  assign wr_on   = bus_sel_i && bus_we_i && (bus_addr_i == ADDR_W'(8'h20));
  assign wr_off  = bus_sel_i && bus_we_i && (bus_addr_i == ADDR_W'(8'h24));
  assign rd_stat = bus_sel_i && !bus_we_i && (bus_addr_i == ADDR_W'(8'h2C));

  assert_mask_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_on |=> ((mask_i & $past(bus_wdata_i)) == $past(bus_wdata_i)));

  assert_mask_clr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_off |=> ((mask_i & $past(bus_wdata_i)) == '0));

  assert_read_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_stat && evt_i == '0) |=> (stat_i == '0));

  assert_evt_kept_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i != '0) |=> ((stat_i & $past(evt_i)) == $past(evt_i)));

  assert_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_stat |=> ((stat_i & $past(stat_i)) == $past(stat_i)));

  assert_irq_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_off && bus_wdata_i == '1) |=> !irq_o);

  assert_warmup_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !warm_i |-> (evt_i == '0));
endmodule

bind line_event_irq lei_chk #(.N(NUM_LINES), .ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bus_sel_i  (bus_sel_i),
  .bus_we_i   (bus_we_i),
  .bus_addr_i (bus_addr_i),
  .bus_wdata_i(bus_wdata_i),
  .irq_o      (irq_o),
  .mask_i     (mask_w),
  .stat_i     (stat_w),
  .evt_i      (evt_w),
  .warm_i     (warm_w)
);

// File: tb/line_event_irq_tb.sv
`timescale 1ns/1ps
module line_event_irq_tb;
  localparam int N = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  line = '1;
  logic [3*N-1:0] sel;
  logic [N-1:0]  fen = '0, fslow = '0;
  logic          tick = 1'b0;
  logic          bsel = 1'b0, bwe = 1'b0;
  logic [7:0]    baddr = '0;
  logic [N-1:0]  bwdata = '0;
  logic [N-1:0]  brdata;
  logic          irq;

  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  line_event_irq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .line_i(line), .evt_sel_i(sel),
    .filt_en_i(fen), .filt_slow_i(fslow), .slow_tick_i(tick),
    .bus_sel_i(bsel), .bus_we_i(bwe), .bus_addr_i(baddr),
    .bus_wdata_i(bwdata), .bus_rdata_o(brdata), .irq_o(irq)
  );

  // slow tick every 8 cycles
  initial begin
    int c = 0;
    forever begin
      @(negedge clk);
      tick = (c % 8 == 7);
      c++;
    end
  end

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [N-1:0] d);
    bsel = 1'b1; bwe = 1'b1; baddr = a; bwdata = d;
    @(negedge clk);
    bsel = 1'b0; bwe = 1'b0; bwdata = '0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [N-1:0] d);
    bsel = 1'b1; bwe = 1'b0; baddr = a;
    #5 d = brdata;
    @(negedge clk);
    bsel = 1'b0; baddr = 8'h00;
  endtask

  task automatic set_sel_rot(input int k);
    for (int l = 0; l < N; l++) sel[3*l +: 3] = 3'((l + k) % 8);
  endtask

  task automatic set_sel_all(input logic [2:0] c);
    for (int l = 0; l < N; l++) sel[3*l +: 3] = c;
  endtask

  function automatic logic [N-1:0] exp_for(input int k, input logic [7:0] codes);
    logic [N-1:0] e = '0;
    for (int l = 0; l < N; l++) if (codes[(l + k) % 8]) e[l] = 1'b1;
    return e;
  endfunction

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [N-1:0] rd;
    set_sel_all(3'd1);
    cyc(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", {31'd0, irq}, '0);
    bus_rd(8'h28, rd); chk("R1 enable set", rd, '0);
    bus_rd(8'h2C, rd); chk("R1 status", rd, '0);
    cyc(10);
    // R10 steady high lines with rise code: no spurious edge
    bus_rd(8'h2C, rd); chk("R10 no spurious edge", rd, '0);
    // R11 unused address
    bus_rd(8'h10, rd); chk("R11 unused addr", rd, '0);

    // R2 sweep: every line sees every code
    for (int k = 0; k < 8; k++) begin
      line = '0; set_sel_rot(k);
      cyc(6);
      bus_rd(8'h2C, rd);
      bus_rd(8'h2C, rd); chk("R2 low hold", rd, exp_for(k, 8'b0000_1000));
      line = '1; cyc(5);
      bus_rd(8'h2C, rd); chk("R2 rise", rd, exp_for(k, 8'b0001_1110));
      bus_rd(8'h2C, rd); chk("R6 high hold", rd, exp_for(k, 8'b0001_0000));
      line = '0; cyc(5);
      bus_rd(8'h2C, rd); chk("R2 fall", rd, exp_for(k, 8'b0001_1101));
      bus_rd(8'h2C, rd); chk("R6 low hold", rd, exp_for(k, 8'b0000_1000));
    end

    // R3 enables, R7 latch while disabled, R8 irq
    set_sel_all(3'd4); line = '0; cyc(5);
    bus_wr(8'h20, 32'h0000_00FF);
    bus_rd(8'h28, rd); chk("R3 enable on", rd, 32'h0000_00FF);
    bus_wr(8'h24, 32'h0000_000F);
    bus_rd(8'h28, rd); chk("R3 enable off", rd, 32'h0000_00F0);
    bus_rd(8'h2C, rd);
    bus_rd(8'h2C, rd); chk("R4 cleared", rd, '0);
    chk("R8 irq idle", {31'd0, irq}, '0);
    line[2] = 1'b1; cyc(5);
    chk("R8 disabled line no irq", {31'd0, irq}, '0);
    bus_rd(8'h2C, rd); chk("R7 latched while disabled", rd, 32'h0000_0004);
    line[5] = 1'b1; cyc(5);
    chk("R8 enabled line irq", {31'd0, irq}, 32'd1);
    bus_wr(8'h24, '1);
    chk("R8 irq drops after disable", {31'd0, irq}, '0);
    line = '0; cyc(5);
    bus_rd(8'h2C, rd);
    bus_rd(8'h2C, rd); chk("R4 cleared again", rd, '0);

    // R6 level reasserts after read
    line[3] = 1'b1; cyc(5);
    bus_rd(8'h2C, rd); chk("R6 level first", rd, 32'h0000_0008);
    bus_rd(8'h2C, rd); chk("R6 level again", rd, 32'h0000_0008);
    line = '0; cyc(5);
    bus_rd(8'h2C, rd);

    // R5 event during the read cycle
    set_sel_all(3'd1); cyc(4);
    bus_rd(8'h2C, rd);
    line[7] = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    bus_rd(8'h2C, rd); chk("R5 not yet visible", rd, '0);
    bus_rd(8'h2C, rd); chk("R5 kept across clear", rd, 32'h0000_0080);
    bus_rd(8'h2C, rd); chk("R4 empty after read", rd, '0);
    line = '0; cyc(5);
    bus_rd(8'h2C, rd);

    // R9 glitch filter
    fen = 32'h0000_0003; fslow = 32'h0000_0001;
    cyc(20);
    bus_rd(8'h2C, rd);
    line[2:0] = 3'b111; cyc(3); line[2:0] = 3'b000;
    cyc(20);
    bus_rd(8'h2C, rd); chk("R9 short pulse", rd, 32'h0000_0006);
    line[2:0] = 3'b111; cyc(40);
    bus_rd(8'h2C, rd); chk("R9 long pulse", rd, 32'h0000_0007);
    line = '0; cyc(40);
    bus_rd(8'h2C, rd);
    bus_rd(8'h2C, rd); chk("R9 settled", rd, '0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule